// File: doc/BRIEF.md
# Multi-Cycle Fetch-Execute Sequencer

This block is the control sequencer of a small multi-cycle RV32 integer core. It fetches one instruction word at a time from a synchronous instruction memory with one cycle of read latency, decodes its class and either computes the result with its own single-cycle ALU or hands the operation to an external multiply/divide unit. The core holds a 32-entry register file. Every result leaves through a writeback port, so a bench can compare each retired instruction against a reference. An instruction word the core does not recognise stops it for good and shows the faulting address and word.

The machine has six named states. FETCH drives the PC onto the memory address with the read enable high. LATCH captures the returned word into the instruction register. EXEC decodes the word and takes one of three paths. For an ALU instruction it captures the result and goes to WB. For a multiply/divide instruction it pulses the start line and goes to MWAIT. For anything else it goes to HALT. MWAIT stays put until the done pulse, captures the result and goes to WB. WB writes the register file, moves the PC on by four and returns to FETCH. HALT has no exit. The transitions are FETCH->LATCH, LATCH->EXEC, EXEC->WB (ALU), EXEC->MWAIT (multiply/divide), EXEC->HALT (unknown), MWAIT->MWAIT (no done), MWAIT->WB (done), WB->FETCH and HALT->HALT.

Top module: `fx_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after it, `pc_out` and `imem_addr` equal 0x2000_0000, the read enable is high, and `wb_en`, `mu_start` and `halted` are low.
- R2: An ALU instruction takes exactly four cycles. The read enable is high only in the fetch cycle, and the writeback comes three cycles after the fetch cycle.
- R3: `pc_out` stays unchanged in every cycle except the writeback cycle. It rises by exactly 4 at the end of that cycle, including during a multiply/divide wait. During the writeback it still shows the address of the retiring instruction.
- R4: The ALU instructions are opcode 0010011 with an immediate and opcode 0110011 with funct7 0000000. Funct7 0100000 with funct3 000 gives subtract, and with funct3 101 gives arithmetic right shift (bit 30 chooses this for the immediate shift too). Each of them writes back the RV32 result of its funct3 operation.
- R5: Opcode 0110011 with funct7 0000001 raises `mu_start` for exactly one cycle. In that cycle it presents funct3 and the rs1 and rs2 values, and it does not raise `mu_start` again while waiting for `mu_done`.
- R6: `mu_result` is sampled only in a cycle where `mu_done` is high. The writeback comes in the next cycle and uses the destination register captured at issue, even if the memory read data changes during the wait.
- R7: A result whose destination is x0 produces no write enable and leaves x0 reading zero. The PC still advances.
- R8: `wb_en` is high for exactly one cycle per retired instruction that has a non-zero destination. `wb_rd` and `wb_data` are valid in that same cycle.
- R9: An unrecognised word sets `halted` permanently. `fault_pc` and `fault_instr` then show its address and word, and after that there is no fetch, no writeback and no start.
- R10: The multiply/divide unit may take any number of cycles from one upward, and the sequencer waits for each of them correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_en | output | 1 | Instruction memory read enable |
| imem_addr | output | 32 | Instruction byte address |
| imem_rdata | input | 32 | Read data, valid one cycle after the enable |
| mu_start | output | 1 | One-cycle request to the multiply/divide unit |
| mu_funct3 | output | 3 | Operation select for the multiply/divide unit |
| mu_opa | output | 32 | rs1 value |
| mu_opb | output | 32 | rs2 value |
| mu_done | input | 1 | Completion pulse from the unit |
| mu_result | input | 32 | Unit result, valid with done |
| wb_en | output | 1 | Register write enable |
| wb_rd | output | 5 | Destination register index |
| wb_data | output | 32 | Written value |
| pc_out | output | 32 | Current program counter |
| halted | output | 1 | Core stopped on an unknown word |
| fault_pc | output | 32 | Address of the faulting word |
| fault_instr | output | 32 | The faulting word |

## Verification
A state that advances too early shows up within one instruction. Either `pc_out` moves outside a writeback, or a writeback carries the address of the wrong instruction, and both are compared on every retirement. A lost destination or a result sampled too early shows up in the first writeback after a multiply/divide wait. A start issued twice shows up at the unit model in the next cycle. Sending the wrong class from the decoder shows up either as an unexpected halt or as a missing halt at the final, deliberately unknown word.

// File: rtl/fx_pkg.sv
`timescale 1ns/1ps
package fx_pkg;
    typedef enum logic [2:0] {
        S_FETCH, S_LATCH, S_EXEC, S_MWAIT, S_WB, S_HALT
    } seq_state_e;

    typedef enum logic [1:0] {
        K_ALU, K_MUL, K_ILL
    } op_kind_e;

    localparam logic [6:0] OPC_IMM   = 7'b0010011;
    localparam logic [6:0] OPC_REG   = 7'b0110011;
    localparam logic [6:0] F7_BASE   = 7'b0000000;
    localparam logic [6:0] F7_ALT    = 7'b0100000;
    localparam logic [6:0] F7_MULDIV = 7'b0000001;
endpackage

// File: rtl/fx_decode.sv
`timescale 1ns/1ps
module fx_decode
    import fx_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int RW   = 5
) (
    input  logic [31:0]     instr,
    output op_kind_e        kind,
    output logic [2:0]      f3,
    output logic            alt,
    output logic            use_imm,
    output logic [XLEN-1:0] imm,
    output logic [RW-1:0]   rs1,
    output logic [RW-1:0]   rs2,
    output logic [RW-1:0]   rd
);
    logic [6:0] opc;
    logic [6:0] f7;

    assign opc = instr[6:0];
    assign f7  = instr[31:25];
    assign f3  = instr[14:12];
    assign rd  = instr[7 +: RW];
    assign rs1 = instr[15 +: RW];
    assign rs2 = instr[20 +: RW];
    assign imm = {{(XLEN-12){instr[31]}}, instr[31:20]};

    always_comb begin
        kind    = K_ILL;
        alt     = 1'b0;
        use_imm = 1'b0;
        if (opc == OPC_IMM) begin
            use_imm = 1'b1;
            if (f3 == 3'b001) begin
                if (f7 == F7_BASE) kind = K_ALU;
            end else if (f3 == 3'b101) begin
                if (f7 == F7_BASE || f7 == F7_ALT) begin
                    kind = K_ALU;
                    alt  = instr[30];
                end
            end else begin
                kind = K_ALU;
            end
        end else if (opc == OPC_REG) begin
            if (f7 == F7_BASE) begin
                kind = K_ALU;
            end else if (f7 == F7_MULDIV) begin
                kind = K_MUL;
            end else if (f7 == F7_ALT && (f3 == 3'b000 || f3 == 3'b101)) begin
                kind = K_ALU;
                alt  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fx_alu.sv
`timescale 1ns/1ps
module fx_alu #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [2:0]      f3,
    input  logic            alt,
    output logic [XLEN-1:0] y
);
    localparam int SHW = $clog2(XLEN);
    logic [SHW-1:0] sh;
    assign sh = b[SHW-1:0];

    always_comb begin
        unique case (f3)
            3'b000: y = alt ? (a - b) : (a + b);
            3'b001: y = a << sh;
            3'b010: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            3'b011: y = {{(XLEN-1){1'b0}}, (a < b)};
            3'b100: y = a ^ b;
            3'b101: y = alt ? XLEN'($signed(a) >>> sh) : (a >> sh);
            3'b110: y = a | b;
            default: y = a & b;
        endcase
    end
endmodule

// File: rtl/fx_regfile.sv
`timescale 1ns/1ps
module fx_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int RW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [RW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [RW-1:0]   ra1,
    input  logic [RW-1:0]   ra2,
    output logic [XLEN-1:0] rd1,
    output logic [XLEN-1:0] rd2
);
    logic [XLEN-1:0] regs_q [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else if (we && waddr != '0) begin
            regs_q[waddr] <= wdata;
        end
    end

    assign rd1 = regs_q[ra1];
    assign rd2 = regs_q[ra2];

    // R7
    x0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ra1 == '0) |-> (rd1 == '0));
endmodule

// File: rtl/fx_sequencer.sv
`timescale 1ns/1ps
module fx_sequencer
    import fx_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              NREG     = 32,
    parameter logic [XLEN-1:0] RESET_PC = 32'h2000_0000,
    localparam int             RW       = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic            imem_en,
    output logic [XLEN-1:0] imem_addr,
    input  logic [31:0]     imem_rdata,
    output logic            mu_start,
    output logic [2:0]      mu_funct3,
    output logic [XLEN-1:0] mu_opa,
    output logic [XLEN-1:0] mu_opb,
    input  logic            mu_done,
    input  logic [XLEN-1:0] mu_result,
    output logic            wb_en,
    output logic [RW-1:0]   wb_rd,
    output logic [XLEN-1:0] wb_data,
    output logic [XLEN-1:0] pc_out,
    output logic            halted,
    output logic [XLEN-1:0] fault_pc,
    output logic [31:0]     fault_instr
);
    seq_state_e      state_q, state_d;
    logic [XLEN-1:0] pc_q, res_q, fpc_q;
    logic [31:0]     ir_q, fir_q;
    logic [RW-1:0]   rd_q;

    op_kind_e        kind;
    logic [2:0]      f3;
    logic            alt, use_imm;
    logic [XLEN-1:0] imm, rv1, rv2, alu_b, alu_y;
    logic [RW-1:0]   rs1, rs2, rd;

    fx_decode #(.XLEN(XLEN), .RW(RW)) u_dec (
        .instr(ir_q), .kind(kind), .f3(f3), .alt(alt), .use_imm(use_imm),
        .imm(imm), .rs1(rs1), .rs2(rs2), .rd(rd)
    );

    fx_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(wb_en), .waddr(rd_q), .wdata(res_q),
        .ra1(rs1), .ra2(rs2), .rd1(rv1), .rd2(rv2)
    );

    assign alu_b = use_imm ? imm : rv2;

    fx_alu #(.XLEN(XLEN)) u_alu (
        .a(rv1), .b(alu_b), .f3(f3), .alt(alt), .y(alu_y)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_FETCH;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_FETCH: state_d = S_LATCH;
            S_LATCH: state_d = S_EXEC;
            S_EXEC: begin
                if (kind == K_ALU)      state_d = S_WB;
                else if (kind == K_MUL) state_d = S_MWAIT;
                else                    state_d = S_HALT;
            end
            S_MWAIT: if (mu_done) state_d = S_WB;
            S_WB:    state_d = S_FETCH;
            S_HALT:  state_d = S_HALT;
            default: state_d = S_HALT;
        endcase
    end

    // outputs
    always_comb begin
        imem_en  = (state_q == S_FETCH);
        mu_start = (state_q == S_EXEC) && (kind == K_MUL);
        wb_en    = (state_q == S_WB) && (rd_q != '0);
        halted   = (state_q == S_HALT);
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= RESET_PC;
            ir_q  <= '0;
            rd_q  <= '0;
            res_q <= '0;
            fpc_q <= '0;
            fir_q <= '0;
        end else begin
            if (state_q == S_LATCH) ir_q <= imem_rdata;
            if (state_q == S_EXEC) begin
                rd_q <= rd;
                if (kind == K_ALU) res_q <= alu_y;
                if (kind == K_ILL) begin
                    fpc_q <= pc_q;
                    fir_q <= ir_q;
                end
            end
            if (state_q == S_MWAIT && mu_done) res_q <= mu_result;
            if (state_q == S_WB) pc_q <= pc_q + XLEN'(4);
        end
    end

    assign imem_addr   = pc_q;
    assign pc_out      = pc_q;
    assign mu_funct3   = f3;
    assign mu_opa      = rv1;
    assign mu_opb      = rv2;
    assign wb_rd       = rd_q;
    assign wb_data     = res_q;
    assign fault_pc    = fpc_q;
    assign fault_instr = fir_q;

    // R3
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_WB) |=> $stable(pc_out));
    // R3
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WB) |=> (pc_out == $past(pc_out) + XLEN'(4)));
    // R5
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mu_start |=> !mu_start);
    // R5
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_MWAIT) |-> !mu_start);
    // R6
    done_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_MWAIT && mu_done) |=> (wb_data == $past(mu_result)));
    // R8
    wb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> !wb_en);
    // R7
    no_x0_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (wb_rd != '0));
    // R9
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(fault_pc) && $stable(fault_instr)));
    // R9
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!imem_en && !wb_en && !mu_start));
endmodule

// File: tb/sim_fx_sequencer.sv
`timescale 1ns/1ps
module sim_fx_sequencer;
    localparam logic [31:0] BASE = 32'h2000_0000;

    typedef struct {
        logic [4:0]  rd;
        logic [31:0] data;
        logic [31:0] pc;
    } wb_item_t;

    typedef struct {
        logic [2:0]  f3;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] res;
        int          lat;
    } mu_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        imem_en;
    logic [31:0] imem_addr;
    logic [31:0] imem_rdata = 32'hDEAD_BEEF;
    logic        mu_start;
    logic [2:0]  mu_funct3;
    logic [31:0] mu_opa, mu_opb;
    logic        mu_done = 1'b0;
    logic [31:0] mu_result = 32'hBAD0_BAD0;
    logic        wb_en;
    logic [4:0]  wb_rd;
    logic [31:0] wb_data, pc_out, fault_pc, fault_instr;
    logic        halted;

    int checks = 0;
    int errors = 0;
    int n_instr = 0;
    logic [31:0] mem [64];
    wb_item_t wq[$];
    mu_item_t mq[$];

    always #2.5 clk = ~clk;

    fx_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .imem_en(imem_en), .imem_addr(imem_addr),
        .imem_rdata(imem_rdata), .mu_start(mu_start), .mu_funct3(mu_funct3),
        .mu_opa(mu_opa), .mu_opb(mu_opb), .mu_done(mu_done), .mu_result(mu_result),
        .wb_en(wb_en), .wb_rd(wb_rd), .wb_data(wb_data), .pc_out(pc_out),
        .halted(halted), .fault_pc(fault_pc), .fault_instr(fault_instr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
                                          input logic [2:0] f3, input logic [4:0] rd);
        return {imm, rs1, f3, rd, 7'b0010011};
    endfunction

    function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2,
                                          input logic [4:0] rs1, input logic [2:0] f3,
                                          input logic [4:0] rd);
        return {f7, rs2, rs1, f3, rd, 7'b0110011};
    endfunction

    // driver: place a word and push the writeback it must produce
    task automatic put(input logic [31:0] w, input bit has_wb,
                       input logic [4:0] rd, input logic [31:0] data);
        wb_item_t it;
        mem[n_instr] = w;
        if (has_wb) begin
            it.rd = rd; it.data = data; it.pc = BASE + 32'(4 * n_instr);
            wq.push_back(it);
        end
        n_instr++;
    endtask

    task automatic put_mu(input logic [2:0] f3, input logic [4:0] rd, input logic [4:0] rs1,
                          input logic [4:0] rs2, input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] res, input int lat);
        mu_item_t m;
        m.f3 = f3; m.a = a; m.b = b; m.res = res; m.lat = lat;
        mq.push_back(m);
        put(enc_r(7'b0000001, rs2, rs1, f3, rd), 1'b1, rd, res);
    endtask

    // synchronous instruction memory, one cycle latency; garbage when idle
    always @(posedge clk) begin
        if (imem_en) imem_rdata <= mem[(imem_addr - BASE) >> 2];
        else         imem_rdata <= 32'hDEAD_BEEF;
    end

    // multiply/divide unit model
    mu_item_t cur;
    bit       busy = 1'b0;
    int       cnt = 0;
    logic [31:0] hold_pc;
    always @(negedge clk) begin
        if (mu_done) begin
            mu_done   = 1'b0;
            mu_result = 32'hBAD0_BAD0;
        end
        if (busy) begin
            // R3 PC held while waiting
            chk(pc_out == hold_pc, "R3", "pc during wait", pc_out, hold_pc);
            if (cnt <= 1) begin
                mu_done   = 1'b1;
                mu_result = cur.res;
                busy      = 1'b0;
            end else begin
                cnt--;
            end
        end
        if (rst_n && mu_start) begin
            // R5 no start while busy or pending done
            chk(!busy && !mu_done, "R5", "restart while waiting", 32'(busy), 32'd0);
            if (mq.size() == 0) begin
                chk(1'b0, "R5", "unexpected start", 32'd1, 32'd0);
            end else begin
                cur = mq.pop_front();
                chk(mu_funct3 == cur.f3, "R5", "funct3", 32'(mu_funct3), 32'(cur.f3));
                chk(mu_opa == cur.a, "R5", "rs1 value", mu_opa, cur.a);
                chk(mu_opb == cur.b, "R5", "rs2 value", mu_opb, cur.b);
                busy    = 1'b1;
                cnt     = cur.lat;
                hold_pc = pc_out;
            end
        end
    end

    // monitor: compare every writeback against the scoreboard
    always @(negedge clk) begin
        if (rst_n && wb_en) begin
            if (wq.size() == 0) begin
                chk(1'b0, "R8", "unexpected writeback", 32'(wb_rd), 32'd0);
            end else begin
                wb_item_t e;
                e = wq.pop_front();
                chk(wb_rd == e.rd, "R6", "destination", 32'(wb_rd), 32'(e.rd));
                chk(wb_data == e.data, "R4", "writeback data", wb_data, e.data);
                chk(pc_out == e.pc, "R3", "pc at retirement", pc_out, e.pc);
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #100000;
        chk(1'b0, "R9", "watchdog expired", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'hFFFF_FFFF;
        // R4 ALU programme
        put(enc_i(12'd5, 5'd0, 3'b000, 5'd1), 1'b1, 5'd1, 32'd5);
        put(enc_i(12'hFFD, 5'd0, 3'b000, 5'd2), 1'b1, 5'd2, 32'hFFFF_FFFD);
        put(enc_r(7'd0, 5'd2, 5'd1, 3'b000, 5'd3), 1'b1, 5'd3, 32'd2);
        put(enc_r(7'b0100000, 5'd2, 5'd1, 3'b000, 5'd4), 1'b1, 5'd4, 32'd8);
        put(enc_i(12'd0, 5'd2, 3'b010, 5'd5), 1'b1, 5'd5, 32'd1);
        put(enc_r(7'd0, 5'd2, 5'd1, 3'b011, 5'd6), 1'b1, 5'd6, 32'd1);
        put(enc_i(12'h00F, 5'd1, 3'b100, 5'd7), 1'b1, 5'd7, 32'd10);
        put(enc_i({7'b0100000, 5'd1}, 5'd2, 3'b101, 5'd8), 1'b1, 5'd8, 32'hFFFF_FFFE);
        put(enc_i({7'b0000000, 5'd28}, 5'd2, 3'b101, 5'd9), 1'b1, 5'd9, 32'h0000_000F);
        put(enc_i({7'b0000000, 5'd3}, 5'd1, 3'b001, 5'd10), 1'b1, 5'd10, 32'd40);
        put(enc_r(7'd0, 5'd7, 5'd1, 3'b111, 5'd11), 1'b1, 5'd11, 32'd0);
        put(enc_r(7'd0, 5'd7, 5'd1, 3'b110, 5'd12), 1'b1, 5'd12, 32'd15);
        // R7 write to x0 dropped, then x0 read back as zero
        put(enc_i(12'd7, 5'd1, 3'b000, 5'd0), 1'b0, 5'd0, 32'd0);
        put(enc_r(7'd0, 5'd1, 5'd0, 3'b000, 5'd13), 1'b1, 5'd13, 32'd5);
        // R5 R6 R10 multiply/divide with varied latency
        put_mu(3'b000, 5'd14, 5'd1, 5'd2, 32'd5, 32'hFFFF_FFFD, 32'hFFFF_FFF1, 1);
        put_mu(3'b101, 5'd15, 5'd7, 5'd1, 32'd10, 32'd5, 32'd2, 7);
        put_mu(3'b111, 5'd16, 5'd12, 5'd4, 32'd15, 32'd8, 32'd7, 3);
        put_mu(3'b011, 5'd17, 5'd2, 5'd2, 32'hFFFF_FFFD, 32'hFFFF_FFFD, 32'hFFFF_FFFA, 2);
        put(enc_r(7'd0, 5'd15, 5'd14, 3'b000, 5'd18), 1'b1, 5'd18, 32'hFFFF_FFF3);
        // R9 unknown word (already filled with all ones) at index 19

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(pc_out == BASE, "R1", "pc in reset", pc_out, BASE);
        chk(!wb_en, "R1", "wb_en in reset", 32'(wb_en), 32'd0);
        chk(!mu_start, "R1", "mu_start in reset", 32'(mu_start), 32'd0);
        chk(!halted, "R1", "halted in reset", 32'(halted), 32'd0);
        rst_n = 1'b1;
        #1;
        chk(imem_en && imem_addr == BASE, "R1", "first fetch address", imem_addr, BASE);
        @(negedge clk);
        // R2 latch cycle has no read enable
        chk(!imem_en, "R2", "enable after fetch", 32'(imem_en), 32'd0);
        @(negedge clk);
        chk(!wb_en, "R2", "no writeback in execute", 32'(wb_en), 32'd0);
        @(negedge clk);
        chk(wb_en && wb_rd == 5'd1, "R2", "writeback three cycles after fetch", 32'(wb_en), 32'd1);
        @(negedge clk);
        // R3 next fetch at base + 4
        chk(imem_en && imem_addr == BASE + 32'd4, "R3", "second fetch address",
            imem_addr, BASE + 32'd4);

        for (int c = 0; c < 2000; c++) begin
            if (halted) break;
            @(negedge clk);
        end
        // R9 halt reporting
        chk(halted, "R9", "halted flag", 32'(halted), 32'd1);
        chk(fault_pc == BASE + 32'd76, "R9", "fault pc", fault_pc, BASE + 32'd76);
        chk(fault_instr == 32'hFFFF_FFFF, "R9", "fault word", fault_instr, 32'hFFFF_FFFF);
        chk(pc_out == BASE + 32'd76, "R9", "pc frozen at fault", pc_out, BASE + 32'd76);
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            chk(halted && !imem_en && !wb_en && !mu_start, "R9", "quiet after halt",
                {28'd0, halted, imem_en, wb_en, mu_start}, 32'h8);
        end
        // R8 every expected writeback seen; R6 every M op issued
        chk(wq.size() == 0, "R8", "writebacks outstanding", 32'(wq.size()), 32'd0);
        chk(mq.size() == 0, "R6", "M ops outstanding", 32'(mq.size()), 32'd0);
        finish_run();
    end
endmodule